// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block routes software-generated interrupts between up to eight processors. Any processor may issue a 32-bit command word on a shared request port. The block decodes a target selection from that word and records one pending entry, keyed by interrupt number and requesting processor, in the state of every processor that is targeted. The selection can be the requester alone, every processor except the requester, or an explicit bit list.

Each processor has its own handshake with the block. An acknowledge strobe claims one deliverable entry, moves it from pending to active, and returns the interrupt number and the source processor in a registered read word. The processor later retires the entry in one of two ways. It can write the acknowledge value back as an end-of-interrupt. It can also write a mask to a clear-active port, which clears active state per interrupt number. A per-processor interrupt line shows whether anything is waiting to be claimed. An entry whose (interrupt, source) pair is still active on a processor stays pending and is not delivered until that pair is retired.

Top module: `sgi_dispatch`

## Requirements
- R1: A command with filter bits [25:24] = 2 marks the entry pending only on the requesting processor (`cmd_src`).
- R2: Filter value 1 marks the entry pending on every processor except the requester.
- R3: Filter value 0 marks the entry pending on the processors whose bits are set in the target list, bits [23:16] (bit 16 is processor 0). Filter value 3 changes nothing.
- R4: The interrupt number is taken from command bits [3:0]. Bits [15:4] and [31:26] have no effect.
- R5: The `ack_data` word for a processor is 0 after reset. It is updated one clock after `ack_rd` and holds otherwise. The interrupt number sits in bits [9:0], the source processor in bits [12:10], and all other bits are zero.
- R6: If a processor has no deliverable entry, an acknowledge returns 1023 in bits [9:0] and changes no state.
- R7: Among deliverable entries, an acknowledge takes the lowest interrupt number first and, for equal numbers, the lowest source.
- R8: An acknowledge moves the entry from pending to active. Writing the acknowledge value to `eoi_data` with `eoi_we` clears that (interrupt, source) active state on that processor.
- R9: A one at bit N of `clr_data` with `clr_we` clears the active state of interrupt N, for all sources, on that processor.
- R10: Each request yields exactly one acknowledge on each targeted processor and none on the others.
- R11: While (interrupt, source) is active on a processor, a new request with the same pair stays pending and is delivered only after the active one is retired.
- R12: After each clock edge, `irq_out[c]` is high exactly when processor c has a pending entry that is not blocked by the same active pair.
- R13: A request that arrives in the same cycle as the acknowledge that claims the same entry stays pending for a later delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_src | input | 3 | Number of the requesting processor |
| cmd_word | input | 32 | Command: filter, target list, interrupt number |
| ack_rd | input | NCPU | Per-processor acknowledge strobe |
| ack_data | output | NCPU*32 | Per-processor registered acknowledge word |
| eoi_we | input | NCPU | Per-processor end-of-interrupt strobe |
| eoi_data | input | NCPU*32 | Per-processor end-of-interrupt value |
| clr_we | input | NCPU | Per-processor clear-active strobe |
| clr_data | input | NCPU*NINT | Per-processor clear-active mask |
| irq_out | output | NCPU | Per-processor interrupt-waiting line |

## Verification
The hardest situation to reach is an entry that is pending but blocked by the same active (interrupt, source) pair, because it only arises when a source repeats a request before the target has retired the earlier one. The stimulus creates it on purpose. It claims an entry, sends the identical request again, and checks that the line stays low and that an acknowledge returns the spurious value. It then retires the pair once by end-of-interrupt and once by clear-active, and watches delivery resume. A request issued in the same cycle as the acknowledge that claims the same entry is driven explicitly to exercise the pending-versus-active update ordering.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int SRCW = 3;
  localparam int IDF  = 10;
  localparam logic [IDF-1:0] SPURIOUS_ID = 10'd1023;

  typedef enum logic [1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_RSVD   = 2'd3
  } filter_e;

  function automatic logic [31:0] ack_word(input logic [IDF-1:0] id,
                                           input logic [SRCW-1:0] src);
    return {19'd0, src, id};
  endfunction
endpackage

// File: rtl/sgi_target_decode.sv
module sgi_target_decode
  import sgi_pkg::*;
#(
  parameter int NCPU = 8
) (
  input  logic            valid,
  input  logic [SRCW-1:0] src,
  input  logic [31:0]     word,
  output logic [NCPU-1:0] tmask
);
  logic [NCPU-1:0] self_bit;
  logic            src_ok;
  filter_e         flt;

  always_comb begin
    for (int k = 0; k < NCPU; k++) self_bit[k] = (src == SRCW'(k));
  end

  assign src_ok = |self_bit;
  assign flt    = filter_e'(word[25:24]);

  always_comb begin
    tmask = '0;
    if (valid && src_ok) begin
      case (flt)
        FLT_LIST:   tmask = word[16 +: NCPU];
        FLT_OTHERS: tmask = ~self_bit;
        FLT_SELF:   tmask = self_bit;
        default:    tmask = '0;
      endcase
    end
  end
endmodule

// File: rtl/sgi_cpu_slice.sv
module sgi_cpu_slice
  import sgi_pkg::*;
#(
  parameter int NCPU = 8,
  parameter int NINT = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NINT*NCPU-1:0] set_vec,
  input  logic                 ack_rd,
  output logic [31:0]          ack_data,
  input  logic                 eoi_we,
  input  logic [31:0]          eoi_data,
  input  logic                 clr_we,
  input  logic [NINT-1:0]      clr_data,
  output logic                 irq
);
  localparam int N    = NINT * NCPU;
  localparam int IDXW = $clog2(N);

  logic [N-1:0]    pend_q, act_q, pend_n, act_n;
  logic [N-1:0]    ready, take, eoi_clr, clr_mask;
  logic            found;
  logic [IDXW-1:0] pidx;
  logic [IDF-1:0]  sel_id;
  logic [SRCW-1:0] sel_src;
  logic [31:0]     ack_q;
  logic            irq_q;
  logic [IDF-1:0]  eoi_id;
  logic [SRCW-1:0] eoi_src;
  logic            unused_eoi;

  assign eoi_id     = eoi_data[IDF-1:0];
  assign eoi_src    = eoi_data[IDF +: SRCW];
  assign unused_eoi = ^eoi_data[31:IDF+SRCW];
  assign ready      = pend_q & ~act_q;

  // lowest index wins: interrupt number major, source minor
  always_comb begin
    found = 1'b0;
    pidx  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (ready[k]) begin
        found = 1'b1;
        pidx  = IDXW'(k);
      end
    end
  end

  assign sel_id  = IDF'(pidx / NCPU);
  assign sel_src = SRCW'(pidx % NCPU);

  always_comb begin
    take = '0;
    if (ack_rd && found) take[pidx] = 1'b1;
  end

  generate
    for (genvar i = 0; i < NINT; i++) begin : g_int
      for (genvar s = 0; s < NCPU; s++) begin : g_src
        assign eoi_clr[i*NCPU+s]  = eoi_we && (eoi_id == IDF'(i)) && (eoi_src == SRCW'(s));
        assign clr_mask[i*NCPU+s] = clr_we && clr_data[i];
      end
    end
  endgenerate

  assign pend_n = (pend_q & ~take) | set_vec;
  assign act_n  = (act_q & ~eoi_clr & ~clr_mask) | take;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      act_q  <= '0;
      irq_q  <= 1'b0;
      ack_q  <= '0;
    end else begin
      pend_q <= pend_n;
      act_q  <= act_n;
      irq_q  <= |(pend_n & ~act_n);
      if (ack_rd) ack_q <= found ? ack_word(sel_id, sel_src) : {22'd0, SPURIOUS_ID};
    end
  end

  assign ack_data = ack_q;
  assign irq      = irq_q;

  p_spurious_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_rd && !found && set_vec == '0) |=> (ack_q[IDF-1:0] == SPURIOUS_ID) && $stable(pend_q) && $stable(act_q));

  p_pick_free_r11: assert property (@(posedge clk) disable iff (rst)
    (ack_rd && found) |-> (pend_q[pidx] && !act_q[pidx]));

  p_claim_grows_r8: assert property (@(posedge clk) disable iff (rst)
    (ack_rd && found && !eoi_we && !clr_we) |=> $countones(act_q) == $past($countones(act_q)) + 1);

  p_irq_state_r12: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(pend_q & ~act_q));
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int NCPU = 8,
  parameter int NINT = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_src,
  input  logic [31:0]          cmd_word,
  input  logic [NCPU-1:0]      ack_rd,
  output logic [NCPU*32-1:0]   ack_data,
  input  logic [NCPU-1:0]      eoi_we,
  input  logic [NCPU*32-1:0]   eoi_data,
  input  logic [NCPU-1:0]      clr_we,
  input  logic [NCPU*NINT-1:0] clr_data,
  output logic [NCPU-1:0]      irq_out
);
  localparam int N   = NINT * NCPU;
  localparam int IDW = $clog2(NINT);

  logic [NCPU-1:0] tmask;
  logic [N-1:0]    cmd_onehot;
  logic            unused_cmd;

  assign unused_cmd = ^{cmd_word[31:26], cmd_word[15:IDW]};

  sgi_target_decode #(.NCPU(NCPU)) u_dec (
    .valid (cmd_valid),
    .src   (cmd_src),
    .word  (cmd_word),
    .tmask (tmask)
  );

  always_comb begin
    for (int i = 0; i < NINT; i++)
      for (int s = 0; s < NCPU; s++)
        cmd_onehot[i*NCPU+s] = (cmd_word[IDW-1:0] == IDW'(i)) && (cmd_src == SRCW'(s));
  end

  generate
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      sgi_cpu_slice #(.NCPU(NCPU), .NINT(NINT)) u_slice (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (tmask[c] ? cmd_onehot : '0),
        .ack_rd   (ack_rd[c]),
        .ack_data (ack_data[c*32 +: 32]),
        .eoi_we   (eoi_we[c]),
        .eoi_data (eoi_data[c*32 +: 32]),
        .clr_we   (clr_we[c]),
        .clr_data (clr_data[c*NINT +: NINT]),
        .irq      (irq_out[c])
      );
    end
  endgenerate

  p_self_only_r1: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_word[25:24] == 2'd2 && (|tmask)) |-> (tmask == (NCPU'(1) << cmd_src)));

  p_reserved_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_word[25:24] == 2'd3) |-> (tmask == '0));

  p_others_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_word[25:24] == 2'd1 && (|tmask)) |-> ($countones(tmask) == NCPU - 1));
endmodule

// File: tb/sgi_dispatch_test.sv
module sgi_dispatch_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 8;
  localparam int NI = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic [2:0]        cmd_src = '0;
  logic [31:0]       cmd_word = '0;
  logic [NC-1:0]     ack_rd = '0;
  logic [NC*32-1:0]  ack_data;
  logic [NC-1:0]     eoi_we = '0;
  logic [NC*32-1:0]  eoi_data = '0;
  logic [NC-1:0]     clr_we = '0;
  logic [NC*NI-1:0]  clr_data = '0;
  logic [NC-1:0]     irq_out;

  int nchk = 0;
  int nerr = 0;
  bit started = 0;

  bit          mp [NC][NI][NC];
  bit          ma [NC][NI][NC];
  logic [31:0] m_ack [NC];
  bit          m_irq [NC];

  sgi_dispatch #(.NCPU(NC), .NINT(NI)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_src(cmd_src),
    .cmd_word(cmd_word), .ack_rd(ack_rd), .ack_data(ack_data),
    .eoi_we(eoi_we), .eoi_data(eoi_data), .clr_we(clr_we),
    .clr_data(clr_data), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NC; c++) begin
        m_ack[c] = '0;
        m_irq[c] = 0;
        for (int i = 0; i < NI; i++)
          for (int s = 0; s < NC; s++) begin mp[c][i][s] = 0; ma[c][i][s] = 0; end
      end
    end else begin
      for (int c = 0; c < NC; c++) begin
        bit hit, tgt;
        int fi, fs, eid, esr;
        hit = 0; fi = 0; fs = 0;
        for (int i = 0; i < NI; i++)
          for (int s = 0; s < NC; s++)
            if (!hit && mp[c][i][s] && !ma[c][i][s]) begin hit = 1; fi = i; fs = s; end
        if (ack_rd[c]) m_ack[c] = hit ? ((fs << 10) | fi) : 32'd1023;
        tgt = 0;
        if (cmd_valid) begin
          case (cmd_word[25:24])
            2'd0: tgt = cmd_word[16 + c];
            2'd1: tgt = (c != int'(cmd_src));
            2'd2: tgt = (c == int'(cmd_src));
            default: tgt = 0;
          endcase
        end
        if (eoi_we[c]) begin
          eid = int'(eoi_data[c*32 +: 10]);
          esr = int'(eoi_data[c*32+10 +: 3]);
          if (eid < NI) ma[c][eid][esr] = 0;
        end
        if (clr_we[c])
          for (int i = 0; i < NI; i++)
            if (clr_data[c*NI+i]) for (int s = 0; s < NC; s++) ma[c][i][s] = 0;
        if (ack_rd[c] && hit) begin mp[c][fi][fs] = 0; ma[c][fi][fs] = 1; end
        if (tgt) mp[c][cmd_word[3:0]][cmd_src] = 1;
        m_irq[c] = 0;
        for (int i = 0; i < NI; i++)
          for (int s = 0; s < NC; s++)
            if (mp[c][i][s] && !ma[c][i][s]) m_irq[c] = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      for (int c = 0; c < NC; c++) begin
        chk("R12 irq_out vs model", 32'(irq_out[c]), 32'(m_irq[c]));
        chk("R5 ack_data vs model", ack_data[c*32 +: 32], m_ack[c]);
      end
    end
  end

  task automatic send(input int s, input logic [31:0] w);
    cmd_valid = 1'b1; cmd_src = 3'(s); cmd_word = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic ack(input int c, output logic [31:0] v);
    ack_rd[c] = 1'b1;
    @(negedge clk);
    ack_rd[c] = 1'b0;
    v = ack_data[c*32 +: 32];
  endtask

  task automatic eoi(input int c, input logic [31:0] v);
    eoi_we[c] = 1'b1; eoi_data[c*32 +: 32] = v;
    @(negedge clk);
    eoi_we[c] = 1'b0;
  endtask

  task automatic clra(input int c, input logic [15:0] m);
    clr_we[c] = 1'b1; clr_data[c*NI +: NI] = m;
    @(negedge clk);
    clr_we[c] = 1'b0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    started = 1;
    chk("R5 reset irq_out", 32'(irq_out), 32'd0);
    chk("R5 reset ack_data", ack_data[31:0], 32'd0);

    // R1 self delivery, interrupt 1 from processor 1
    send(1, 32'h0200_0001);
    chk("R1 self target", 32'(irq_out), 32'h02);
    ack(1, v);
    chk("R5 ack word source/number", v, 32'h0000_0401);
    ack(1, v);
    chk("R6 second ack spurious", v, 32'd1023);
    chk("R10 single delivery irq low", 32'(irq_out), 32'd0);
    eoi(1, 32'h0000_0401);

    // R2 all except requester
    send(1, 32'h0100_0005);
    chk("R2 others target", 32'(irq_out), 32'hFD);
    for (int c = 0; c < NC; c++) begin
      ack(c, v);
      if (c == 1) chk("R10 requester gets none", v, 32'd1023);
      else begin chk("R2 others ack", v, 32'h0000_0405); eoi(c, v); end
    end
    chk("R10 all delivered once", 32'(irq_out), 32'd0);

    // R3 explicit list
    send(3, 32'h00A4_0007);
    chk("R3 list target", 32'(irq_out), 32'hA4);
    for (int c = 0; c < NC; c++) begin
      if (c == 2 || c == 5 || c == 7) begin
        ack(c, v);
        chk("R3 list ack", v, 32'h0000_0C07);
        eoi(c, v);
      end
    end

    // R3 reserved filter
    send(0, 32'h03FF_0001);
    chk("R3 reserved filter no target", 32'(irq_out), 32'd0);
    ack(0, v);
    chk("R3 reserved filter spurious", v, 32'd1023);

    // R7 ordering on processor 0
    send(4, 32'h0001_0009);
    send(2, 32'h0001_0009);
    send(6, 32'h0001_0003);
    ack(0, v); chk("R7 lowest number first", v, 32'h0000_1803);
    ack(0, v); chk("R7 lowest source next", v, 32'h0000_0809);
    ack(0, v); chk("R7 last entry", v, 32'h0000_1009);

    // R11 blocked by same active pair, R8 retire by EOI
    send(6, 32'h0001_0003);
    chk("R11 blocked irq low", 32'(irq_out[0]), 32'd0);
    ack(0, v); chk("R11 blocked ack spurious", v, 32'd1023);
    eoi(0, 32'h0000_1803);
    chk("R8 eoi unblocks", 32'(irq_out[0]), 32'd1);
    ack(0, v); chk("R8 redelivery after eoi", v, 32'h0000_1803);
    eoi(0, v);

    // R9 clear-active by mask
    send(4, 32'h0001_0009);
    chk("R11 blocked by int 9", 32'(irq_out[0]), 32'd0);
    clra(0, 16'h0200);
    chk("R9 clear-active unblocks", 32'(irq_out[0]), 32'd1);
    ack(0, v); chk("R9 delivery after clear", v, 32'h0000_1009);
    send(2, 32'h0001_0009);
    ack(0, v); chk("R9 other source cleared too", v, 32'h0000_0809);
    clra(0, 16'h0200);

    // R4 noise in unused command bits
    send(5, 32'hFE00_FFF2);
    chk("R4 self with noise", 32'(irq_out), 32'h20);
    ack(5, v); chk("R4 number from low bits", v, 32'h0000_1402);
    eoi(5, v);

    // R13 request coinciding with claim of same entry
    send(0, 32'h0020_0004);
    ack_rd[5] = 1'b1; cmd_valid = 1'b1; cmd_src = 3'd0; cmd_word = 32'h0020_0004;
    @(negedge clk);
    ack_rd[5] = 1'b0; cmd_valid = 1'b0;
    chk("R13 claim result", ack_data[5*32 +: 32], 32'h0000_0004);
    chk("R13 new entry blocked", 32'(irq_out[5]), 32'd0);
    eoi(5, 32'h0000_0004);
    chk("R13 new entry kept", 32'(irq_out[5]), 32'd1);
    ack(5, v); chk("R13 second delivery", v, 32'h0000_0004);
    eoi(5, v);
    ack(5, v); chk("R10 no third delivery", v, 32'd1023);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule